// File: doc/BRIEF.md
# Legacy Register Write Translator

This block sits in front of a four-slot-per-channel operator register array and accepts register writes in the older two-operator address layout: a 9-bit address (bit 8 picks the upper bank) and an 8-bit value. Each accepted write is classified from its low address byte. A per-operator write is mapped onto a native channel, a native slot and a sub-register index from 0 to 7. A per-channel write is mapped onto slot 0 of a native channel. A write to one of the few global registers updates state held inside the block. A write that falls into a hole in the legacy map has no effect.

Native writes leave on a valid/ready stream. The input side has `in_ready` high whenever the output register is empty or being drained in the same cycle (`in_ready = !out_valid || out_ready`). A decoded write appears on the output one clock after it is accepted, and stays unchanged while `out_ready` is low. Writes that produce no native write are still consumed in one cycle. The key-on bits, the rhythm and depth flags, the four-operator enables and the mode flags are plain level outputs. They update on the same clock edge that accepts the write.

Once the native-mode flag is set, this translator stops interpreting writes. Any further write is consumed and dropped until reset.

Top module: `lgx_translator`

## Requirements
- R1: For a per-operator write, the low five address bits v pick a legacy operator: v = 0..5, 8..13 and 16..21 select operators 0..5, 6..11 and 12..17 (operator = 6*(v/8) + v%8). Any other v gives no output strobe and no state change.
- R2: When address bit 8 is set, 18 is added to the legacy operator index, and 9 is added to the channel index of a per-channel write.
- R3: Legacy operator s (0..35) drives `out_chan` = 3*(s/6) + s%3, and `out_slot` = 0 when s%6 < 3, else 1.
- R4: Address bits 7:4 of 2 or 3, 4 or 5, 6 or 7, 8 or 9, and E or F select `out_sub` 0, 1, 2, 3 and 7. `out_data` equals the written value.
- R5: Address bits 7:4 of A, B and C are per-channel writes to slot 0 with `out_sub` 4, 5 and 6. The channel is bits 3:0, valid only up to 8. Larger nibbles, the D range, and unassigned 0x0x addresses produce no strobe.
- R6: A valid B-range write sets `key_on[chan]` from data bit 5. For channel 7 it also sets `key_on_alt[0]`, and for channel 8 it also sets `key_on_alt[1]`.
- R7: A write whose low address byte is 0xBD, in either bank, produces no strobe. It loads `rhythm_flags` from data bits 5:0, `vib_deep` from bit 6 and `trem_deep` from bit 7.
- R8: If data bit 5 of an 0xBD write is set, the same write also loads key-ons: channel 6 from bit 4, channel 7 from bit 0, channel 8 from bit 2, `key_on_alt[0]` from bit 3 and `key_on_alt[1]` from bit 1.
- R9: Address 0x104 loads `four_op_en` from data bits 5:0, where bits 2:0 cover channels 0..2 and bits 5:3 cover channels 9..11. Address 0x105 loads `new_mode` from bit 0 and sets `native_mode` when bit 7 is 1. `native_mode` stays set until reset. The same addresses in the lower bank do nothing.
- R10: An accepted decoded write appears with `out_valid` one clock after acceptance, for one cycle when `out_ready` is high. While `out_valid` is high and `out_ready` is low, the outputs hold and `in_ready` is low.
- R11: While `native_mode` is set, accepted writes produce no strobe and change no state.
- R12: After reset, all outputs are zero except `in_ready`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Legacy write present |
| in_ready | output | 1 | Legacy write can be accepted |
| in_addr | input | 9 | Legacy address, bit 8 selects the upper bank |
| in_data | input | 8 | Legacy write value |
| out_valid | output | 1 | Native write present |
| out_ready | input | 1 | Native write consumed |
| out_chan | output | 5 | Native channel 0..17 |
| out_slot | output | 2 | Native slot within channel |
| out_sub | output | 3 | Sub-register index 0..7 |
| out_data | output | 8 | Native write value |
| key_on | output | 18 | Per-channel key-on |
| key_on_alt | output | 2 | Second key-on of channels 7 and 8 |
| rhythm_flags | output | 6 | Percussion flags |
| vib_deep | output | 1 | Vibrato depth select |
| trem_deep | output | 1 | Tremolo depth select |
| four_op_en | output | 6 | Four-operator enables for channels 0..2 and 9..11 |
| new_mode | output | 1 | Extended-mode flag |
| native_mode | output | 1 | Translator disabled, native addressing in force |

## Verification
A wrong entry in the operator lookup, or a bad bank offset, shows up as a wrong `out_chan` or `out_slot` one clock after the write. It can also show up as a strobe that appears or disappears on a hole address. A sweep over all 512 addresses therefore exposes it within that one write. Corrupted global state, such as a key-on bit loaded from the wrong data bit or a depth flag that sticks, appears on the level outputs at the same edge. The bench compares every level output after every write, so such a fault shows within the write that causes it. Back-pressure faults appear as output fields that change, or an `in_ready` that is high, during the cycles that `out_ready` is held low.

// File: rtl/lgx_pkg.sv
package lgx_pkg;
  localparam int NUM_CH      = 18;
  localparam int CH_W        = $clog2(NUM_CH);
  localparam int SLOT_W      = 2;
  localparam int SUB_W       = 3;
  localparam int DATA_W      = 8;
  localparam int ADDR_W      = 9;
  localparam int LEG_CH_BANK = 9;

  typedef enum logic [2:0] {
    K_NONE,
    K_SLOT,
    K_CHAN,
    K_RHY,
    K_FOUROP,
    K_MODE
  } wr_kind_e;

  typedef struct packed {
    logic [CH_W-1:0]   chan;
    logic [SLOT_W-1:0] slot;
    logic [SUB_W-1:0]  sub;
    logic [DATA_W-1:0] data;
  } nat_wr_t;
endpackage

// File: rtl/lgx_slot_map.sv
module lgx_slot_map #(
  parameter int GROUP_STRIDE = 8,
  parameter int OPS_PER_GROUP = 6,
  parameter int GROUPS = 3,
  parameter int CH_W = 5
) (
  input  logic [4:0]      lo5,
  input  logic            upper,
  output logic            ok,
  output logic [CH_W-1:0] chan,
  output logic            slot1
);
  localparam int ENTRIES   = 32;
  localparam int HALF      = OPS_PER_GROUP / 2;
  localparam int BANK_CH   = GROUPS * HALF;

  logic            lut_ok [ENTRIES];
  logic [CH_W-1:0] lut_ch [ENTRIES];
  logic            lut_s1 [ENTRIES];

  for (genvar v = 0; v < ENTRIES; v++) begin : g_lut
    localparam int GRP = v / GROUP_STRIDE;
    localparam int POS = v % GROUP_STRIDE;
    localparam bit OK  = (POS < OPS_PER_GROUP) && (GRP < GROUPS);
    localparam int OP  = GRP * OPS_PER_GROUP + POS;
    localparam int CH  = HALF * (OP / OPS_PER_GROUP) + (OP % HALF);
    assign lut_ok[v] = OK;
    assign lut_ch[v] = OK ? CH_W'(CH) : '0;
    assign lut_s1[v] = OK && ((OP % OPS_PER_GROUP) >= HALF);
  end

  always_comb begin
    ok    = lut_ok[lo5];
    chan  = lut_ch[lo5] + (upper ? CH_W'(BANK_CH) : CH_W'(0));
    slot1 = lut_s1[lo5];
  end
endmodule

// File: rtl/lgx_addr_class.sv
module lgx_addr_class
  import lgx_pkg::*;
#(
  parameter int MAX_NIB = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output wr_kind_e          kind,
  output logic [SUB_W-1:0]  sub,
  output logic              key_reg,
  output logic              chan_ok,
  output logic [CH_W-1:0]   chan
);
  logic [7:0] low;
  logic       upper;
  assign low   = addr[7:0];
  assign upper = addr[8];

  always_comb begin
    kind    = K_NONE;
    sub     = '0;
    key_reg = 1'b0;
    if (low == 8'hBD) begin
      kind = K_RHY;
    end else begin
      unique case (low[7:4])
        4'h2, 4'h3: begin kind = K_SLOT; sub = 3'd0; end
        4'h4, 4'h5: begin kind = K_SLOT; sub = 3'd1; end
        4'h6, 4'h7: begin kind = K_SLOT; sub = 3'd2; end
        4'h8, 4'h9: begin kind = K_SLOT; sub = 3'd3; end
        4'hE, 4'hF: begin kind = K_SLOT; sub = 3'd7; end
        4'hA:       begin kind = K_CHAN; sub = 3'd4; end
        4'hB:       begin kind = K_CHAN; sub = 3'd5; key_reg = 1'b1; end
        4'hC:       begin kind = K_CHAN; sub = 3'd6; end
        4'h0: begin
          if (upper && low[3:0] == 4'h4) kind = K_FOUROP;
          else if (upper && low[3:0] == 4'h5) kind = K_MODE;
        end
        default: kind = K_NONE;
      endcase
    end
  end

  assign chan_ok = (low[3:0] <= 4'(MAX_NIB));
  assign chan    = CH_W'(low[3:0]) + (upper ? CH_W'(LEG_CH_BANK) : CH_W'(0));
endmodule

// File: rtl/lgx_global_regs.sv
module lgx_global_regs
  import lgx_pkg::*;
#(
  parameter int RHY_CH0 = 6,
  parameter int RHY_CH1 = 7,
  parameter int RHY_CH2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  wr_kind_e          kind,
  input  logic              key_reg,
  input  logic              chan_ok,
  input  logic [CH_W-1:0]   chan,
  input  logic [DATA_W-1:0] data,
  output logic [NUM_CH-1:0] key_on,
  output logic [1:0]        key_on_alt,
  output logic [5:0]        rhythm_flags,
  output logic              vib_deep,
  output logic              trem_deep,
  output logic [5:0]        four_op_en,
  output logic              new_mode,
  output logic              native_mode
);
  logic key_wr;
  assign key_wr = we && kind == K_CHAN && key_reg && chan_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_on       <= '0;
      key_on_alt   <= '0;
      rhythm_flags <= '0;
      vib_deep     <= 1'b0;
      trem_deep    <= 1'b0;
      four_op_en   <= '0;
      new_mode     <= 1'b0;
      native_mode  <= 1'b0;
    end else if (we) begin
      if (key_wr) begin
        key_on[chan] <= data[5];
        if (chan == CH_W'(RHY_CH1)) key_on_alt[0] <= data[5];
        if (chan == CH_W'(RHY_CH2)) key_on_alt[1] <= data[5];
      end
      if (kind == K_RHY) begin
        rhythm_flags <= data[5:0];
        vib_deep     <= data[6];
        trem_deep    <= data[7];
        if (data[5]) begin
          key_on[RHY_CH0] <= data[4];
          key_on[RHY_CH1] <= data[0];
          key_on[RHY_CH2] <= data[2];
          key_on_alt[0]   <= data[3];
          key_on_alt[1]   <= data[1];
        end
      end
      if (kind == K_FOUROP) four_op_en <= data[5:0];
      if (kind == K_MODE) begin
        new_mode <= data[0];
        if (data[7]) native_mode <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/lgx_out_stage.sv
module lgx_out_stage #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  output logic         take,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_q
);
  assign take = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_q     <= '0;
    end else if (take) begin
      out_valid <= load;
      if (load) out_q <= load_data;
    end
  end
endmodule

// File: rtl/lgx_translator.sv
module lgx_translator
  import lgx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_chan,
  output logic [SLOT_W-1:0] out_slot,
  output logic [SUB_W-1:0]  out_sub,
  output logic [DATA_W-1:0] out_data,
  output logic [NUM_CH-1:0] key_on,
  output logic [1:0]        key_on_alt,
  output logic [5:0]        rhythm_flags,
  output logic              vib_deep,
  output logic              trem_deep,
  output logic [5:0]        four_op_en,
  output logic              new_mode,
  output logic              native_mode
);
  localparam int NW = $bits(nat_wr_t);

  wr_kind_e          kind;
  logic [SUB_W-1:0]  sub;
  logic              key_reg, chan_ok, op_ok, op_s1, accept, emit;
  logic [CH_W-1:0]   ch_chan, op_chan;
  nat_wr_t           nw, nq;
  logic [NW-1:0]     nq_bits;

  lgx_addr_class u_class (
    .addr(in_addr), .kind(kind), .sub(sub), .key_reg(key_reg),
    .chan_ok(chan_ok), .chan(ch_chan)
  );

  lgx_slot_map #(.CH_W(CH_W)) u_map (
    .lo5(in_addr[4:0]), .upper(in_addr[8]), .ok(op_ok),
    .chan(op_chan), .slot1(op_s1)
  );

  assign accept = in_valid && in_ready && !native_mode;
  assign emit   = accept && ((kind == K_SLOT && op_ok) || (kind == K_CHAN && chan_ok));

  always_comb begin
    nw.sub  = sub;
    nw.data = in_data;
    if (kind == K_SLOT) begin
      nw.chan = op_chan;
      nw.slot = {1'b0, op_s1};
    end else begin
      nw.chan = ch_chan;
      nw.slot = '0;
    end
  end

  lgx_out_stage #(.W(NW)) u_out (
    .clk(clk), .rst_n(rst_n), .load(emit), .load_data(nw),
    .take(in_ready), .out_ready(out_ready), .out_valid(out_valid), .out_q(nq_bits)
  );

  assign nq       = nat_wr_t'(nq_bits);
  assign out_chan = nq.chan;
  assign out_slot = nq.slot;
  assign out_sub  = nq.sub;
  assign out_data = nq.data;

  lgx_global_regs u_glob (
    .clk(clk), .rst_n(rst_n), .we(accept), .kind(kind), .key_reg(key_reg),
    .chan_ok(chan_ok), .chan(ch_chan), .data(in_data),
    .key_on(key_on), .key_on_alt(key_on_alt), .rhythm_flags(rhythm_flags),
    .vib_deep(vib_deep), .trem_deep(trem_deep), .four_op_en(four_op_en),
    .new_mode(new_mode), .native_mode(native_mode)
  );
endmodule

// File: rtl/lgx_translator_chk.sv
module lgx_translator_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [8:0] in_addr,
  input logic       out_valid,
  input logic       out_ready,
  input logic [4:0] out_chan,
  input logic [1:0] out_slot,
  input logic [2:0] out_sub,
  input logic [7:0] out_data,
  input logic       native_mode
);
  // R10
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_slot)
                                && $stable(out_sub) && $stable(out_data));
  // R10
  stall_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R3
  chan_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_chan < 5'd18 && out_slot <= 2'd1);
  // R5
  chan_write_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_sub == 3'd4 || out_sub == 3'd5 || out_sub == 3'd6) |-> out_slot == 2'd0);
  // R9
  native_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    native_mode |=> native_mode);
  // R7
  rhythm_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_addr[7:0] == 8'hBD |=> !out_valid);
  // R11
  native_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && native_mode |=> !out_valid);
endmodule

bind lgx_translator lgx_translator_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr(in_addr), .out_valid(out_valid), .out_ready(out_ready),
  .out_chan(out_chan), .out_slot(out_slot), .out_sub(out_sub),
  .out_data(out_data), .native_mode(native_mode)
);

// File: tb/tb_lgx_translator.sv
`timescale 1ns/1ps
module tb_lgx_translator;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [8:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, vib_deep, trem_deep, new_mode, native_mode;
  logic [4:0] out_chan;
  logic [1:0] out_slot, key_on_alt;
  logic [2:0] out_sub;
  logic [7:0] out_data;
  logic [17:0] key_on;
  logic [5:0] rhythm_flags, four_op_en;

  always #2.5 clk = ~clk;

  lgx_translator dut (.*);

  int n_cmp = 0, n_bad = 0;
  logic [17:0] m_key;
  logic [1:0]  m_alt;
  logic [5:0]  m_rhy, m_four;
  logic        m_vib, m_trem, m_new, m_nat;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_globals(string tag);
    chk((tag == "R11") ? tag : "R6", "key_on", int'(key_on), int'(m_key));
    chk((tag == "R11") ? tag : "R8", "key_on_alt", int'(key_on_alt), int'(m_alt));
    chk((tag == "R11") ? tag : "R7", "rhythm", int'({trem_deep, vib_deep, rhythm_flags}),
        int'({m_trem, m_vib, m_rhy}));
    chk((tag == "R11") ? tag : "R9", "four_op", int'(four_op_en), int'(m_four));
    chk((tag == "R11") ? tag : "R9", "modes", int'({native_mode, new_mode}), int'({m_nat, m_new}));
  endtask

  task automatic do_write(logic [8:0] a, logic [7:0] d);
    int r, hn, nib, v, s, e_ch, e_sl, e_sub;
    bit hi, e_v;
    string tag;
    r = int'(a[7:0]); hi = a[8]; hn = r / 16; nib = r % 16; v = r % 32;
    e_v = 0; e_ch = 0; e_sl = 0; e_sub = 0; tag = "R9";
    if (r == 'hBD) tag = "R7";
    else if ((hn >= 2 && hn <= 9) || hn >= 14) begin
      tag = "R1";
      e_sub = (hn >= 14) ? 7 : (hn - 2) / 2;
      if ((v % 8) < 6 && (v / 8) < 3) begin
        e_v = 1;
        s = 6 * (v / 8) + (v % 8) + (hi ? 18 : 0);
        e_ch = 3 * (s / 6) + s % 3;
        e_sl = ((s % 6) >= 3) ? 1 : 0;
      end
    end else if (hn >= 10 && hn <= 12) begin
      tag = "R5";
      e_sub = hn - 6;
      if (nib <= 8) begin e_v = 1; e_ch = nib + (hi ? 9 : 0); end
    end
    if (m_nat) begin tag = "R11"; e_v = 0; end
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    if (!m_nat) begin
      if (e_v && hn >= 11 && hn <= 11) begin
        m_key[e_ch] = d[5];
        if (e_ch == 7) m_alt[0] = d[5];
        if (e_ch == 8) m_alt[1] = d[5];
      end
      if (r == 'hBD) begin
        m_rhy = d[5:0]; m_vib = d[6]; m_trem = d[7];
        if (d[5]) begin
          m_key[6] = d[4]; m_key[7] = d[0]; m_key[8] = d[2];
          m_alt[0] = d[3]; m_alt[1] = d[1];
        end
      end
      if (a == 9'h104) m_four = d[5:0];
      if (a == 9'h105) begin m_new = d[0]; if (d[7]) m_nat = 1'b1; end
    end
    chk(tag, "out_valid", int'(out_valid), int'(e_v));
    if (e_v) begin
      chk(hi ? "R2" : "R3", "out_chan", int'(out_chan), e_ch);
      chk("R3", "out_slot", int'(out_slot), e_sl);
      chk("R4", "out_sub", int'(out_sub), e_sub);
      chk("R4", "out_data", int'(out_data), int'(d));
    end
    chk_globals(tag);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] dd;
    m_key = '0; m_alt = '0; m_rhy = '0; m_four = '0;
    m_vib = 0; m_trem = 0; m_new = 0; m_nat = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12", "out_valid", int'(out_valid), 0);
    chk("R12", "in_ready", int'(in_ready), 1);
    chk_globals("R12");
    rst_n = 1'b1;
    for (int pass = 0; pass < 2; pass++) begin
      for (int a = 0; a < 512; a++) begin
        dd = 8'(a) ^ 8'h5A;
        if (pass == 1) dd = ~dd;
        if (a == 'h105) dd[7] = 1'b0;
        do_write(9'(a), dd);
      end
    end
    // R10 back-pressure: first write held, second waits
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_addr = 9'h020; in_data = 8'h11;
    @(negedge clk);
    in_addr = 9'h040; in_data = 8'h22;
    chk("R10", "in_ready stalled", int'(in_ready), 0);
    @(negedge clk);
    chk("R10", "held data", int'(out_data), 'h11);
    chk("R10", "held sub", int'(out_sub), 0);
    chk("R10", "held valid", int'(out_valid), 1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "next data", int'(out_data), 'h22);
    chk("R10", "next sub", int'(out_sub), 1);
    @(negedge clk);
    chk("R10", "one-cycle strobe", int'(out_valid), 0);
    // R9 / R11 native switch, then writes are dropped
    do_write(9'h105, 8'h81);
    do_write(9'h022, 8'h33);
    do_write(9'h0B3, 8'h20);
    do_write(9'h0BD, 8'hFF);
    do_write(9'h104, 8'h3F);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule